// File: doc/BRIEF.md
# Per-Layer Programmable Color Space Converter

This block sits in the pixel path of a multi-layer blender. It converts three 10-bit color components with a signed 3x3 matrix. A signed offset is added to each input component before the multiply. After the products are summed, a signed per-row constant is added. Each layer has its own bank of nine coefficients and three offset/constant words, and its own enable bit. A layer that is not enabled passes its pixels through unchanged.

Software programs the banks through a plain 32-bit write port with a combinational read-back. The programmed values sit in a working copy. They reach the datapath only when a frame-start pulse arrives, and only once every pixel already inside the pipeline has left it. A frame therefore never sees a mix of old and new settings. Pixels stream in and out over valid/ready handshakes, and each pixel carries a layer index.

Top module: `pix_csc`

## Requirements
- R1: After reset, every programmable and shadow register is zero and no layer is enabled. out_valid is low and in_ready is high.
- R2: Bank registers sit at byte address 0x110 + 0x30*L + 0x10*r + 4*w, for layer L, row r and word w. Words 0 to 2 hold the coefficients for input components 0 to 2. Word 3 holds row r's input offset in bits [31:16] and row r's output constant in bits [15:0]. A read returns the last value written. Any address outside the map reads as 0, and a write to such an address changes nothing.
- R3: The control register at 0x100 holds the per-layer enables: bit L enables layer L. Bits at or above NUM_LAYERS read as 0.
- R4: Pixel components are 10-bit codes in units of 1/4. Offsets and constants are signed 16-bit values in those same units. Coefficients are 32-bit two's-complement values with 17 fractional bits. For an enabled layer, output r is (sum over j of c_rj*(in_j + d_j)) / 2^17 + k_r, where d_j is the offset held in row j.
- R5: Each output is rounded half-up at the fractional point, then clamped to the range 0 to 1023.
- R6: Pixels of a layer whose enable bit is clear leave the block with all three components unchanged.
- R7: The layer index selects which bank and which enable bit a pixel uses. It is delivered unchanged on out_layer.
- R8: A pixel accepted at clock edge e appears on the output after edge e+2. With out_ready held high, the block accepts one pixel per clock.
- R9: While out_valid is high and out_ready is low, the output pixel and its layer stay stable, and no pixel is lost or reordered.
- R10: Register writes do not affect any pixel until a frame-start pulse. After the pulse, in_ready stays low until the pipeline is empty. The shadow copy then loads, and every pixel accepted after the load uses the new settings.
- R11: A bank whose columns 1 and 2 are swapped produces, for an input with components 1 and 2 swapped, the same output as the original bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| frame_start | input | 1 | One-cycle pulse requesting a shadow load |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_layer | input | LAYER_W | Layer index of input pixel |
| in_c0 | input | COMP_W | Input component 0 |
| in_c1 | input | COMP_W | Input component 1 |
| in_c2 | input | COMP_W | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_layer | output | LAYER_W | Layer index of output pixel |
| out_c0 | output | COMP_W | Output component 0 |
| out_c1 | output | COMP_W | Output component 1 |
| out_c2 | output | COMP_W | Output component 2 |

## Verification
A pixel accepted at edge e is due on the output after edge e+2. The directed latency case therefore samples out_valid at the three falling edges that follow the acceptance and expects low, low, then high. All other results are matched at the falling edge before the output handshake: a queue of expected pixels is filled at acceptance time and popped in order. Stalls of any length are therefore allowed while still checking order and values. Read data is combinational and is sampled at the falling edge after the address is driven. The blocking of in_ready is sampled at the first falling edge after the edge that captures frame_start.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  localparam int unsigned CTRL_ADDR    = 32'h100;
  localparam int unsigned BANK_BASE    = 32'h110;
  localparam int unsigned LAYER_STRIDE = 32'h30;
  localparam int unsigned ROW_STRIDE   = 32'h10;
  localparam int ROWS  = 3;
  localparam int WORDS = 4;   // three coefficients, then offset/constant
  localparam int FRAC  = 17;

  typedef logic signed [63:0] wide_t;

  // component plus signed offset, both in quarter-code units
  function automatic wide_t pix_offset(input logic [15:0] pix, input logic [15:0] d);
    return wide_t'({48'd0, pix}) + wide_t'(signed'(d));
  endfunction

  // coefficient (17 fractional bits) times offset component
  function automatic wide_t pix_mul(input logic [31:0] c, input wide_t s);
    return wide_t'(signed'(c)) * s;
  endfunction

  // sum, constant, round half-up, clamp to [0, maxv]
  function automatic logic [15:0] pix_finish(input wide_t p0, input wide_t p1,
                                             input wide_t p2, input logic [15:0] k,
                                             input logic [15:0] maxv);
    wide_t acc;
    acc = p0 + p1 + p2 + (wide_t'(signed'(k)) <<< FRAC) + (wide_t'(1) <<< (FRAC - 1));
    acc = acc >>> FRAC;
    if (acc < 0) return 16'd0;
    if (acc > wide_t'({48'd0, maxv})) return maxv;
    return acc[15:0];
  endfunction
endpackage

// File: rtl/csc_regfile.sv
`timescale 1ns/1ps
module csc_regfile
  import csc_pkg::*;
#(
  parameter int NL = 4,
  parameter int AW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic frame_start,
  input  logic pipe_empty,
  output logic upd_pend,
  output logic shadow_load,
  output logic [NL-1:0] sh_en,
  output logic [NL-1:0][ROWS-1:0][WORDS-1:0][31:0] sh_regs
);
  logic [NL-1:0] en_q, sh_en_q;
  logic [NL-1:0][ROWS-1:0][WORDS-1:0][31:0] prog_q, sh_q;
  logic [NL-1:0][ROWS-1:0][WORDS-1:0] hit;
  logic ctrl_hit, pend_q;

  assign ctrl_hit = (addr == AW'(CTRL_ADDR));

  for (genvar l = 0; l < NL; l++) begin : g_lay
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int unsigned A = BANK_BASE + l*LAYER_STRIDE + r*ROW_STRIDE + w*4;
        assign hit[l][r][w] = (addr == AW'(A));
      end
    end
  end

  assign shadow_load = pend_q & pipe_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= '0;
      sh_q    <= '0;
      en_q    <= '0;
      sh_en_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      for (int l = 0; l < NL; l++)
        for (int r = 0; r < ROWS; r++)
          for (int w = 0; w < WORDS; w++)
            if (wr_en && hit[l][r][w]) prog_q[l][r][w] <= wdata;
      if (wr_en && ctrl_hit) en_q <= wdata[NL-1:0];
      if (shadow_load) begin
        sh_q    <= prog_q;
        sh_en_q <= en_q;
      end
      pend_q <= frame_start | (pend_q & ~pipe_empty);
    end
  end

  always_comb begin
    rdata = 32'd0;
    if (ctrl_hit) rdata = 32'(en_q);
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < ROWS; r++)
        for (int w = 0; w < WORDS; w++)
          if (hit[l][r][w]) rdata = prog_q[l][r][w];
  end

  assign upd_pend = pend_q;
  assign sh_en    = sh_en_q;
  assign sh_regs  = sh_q;
endmodule

// File: rtl/csc_pipe.sv
`timescale 1ns/1ps
module csc_pipe
  import csc_pkg::*;
#(
  parameter int NL = 4,
  parameter int CW = 10,
  parameter int LW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NL-1:0] sh_en,
  input  logic [NL-1:0][ROWS-1:0][WORDS-1:0][31:0] sh_regs,
  input  logic upd_pend,
  input  logic in_valid,
  output logic in_ready,
  input  logic [LW-1:0] in_layer,
  input  logic [2:0][CW-1:0] in_pix,
  output logic out_valid,
  input  logic out_ready,
  output logic [LW-1:0] out_layer,
  output logic [2:0][CW-1:0] out_pix,
  output logic pipe_empty,
  output logic accept
);
  localparam int SW = ((CW + 1 > 16) ? CW + 1 : 16) + 1;
  localparam int PW = 32 + SW;
  localparam logic [15:0] MAXV = 16'((1 << CW) - 1);
  localparam bit POW2 = ((1 << LW) == NL);

  logic adv, lay_ok;
  logic [LW-1:0] ix0;
  logic v1, v2, v3, en1, en2;
  logic [LW-1:0] lay1, lay2, ix1, ix2, lay3;
  logic [2:0][CW-1:0] raw1, raw2, pix3;
  logic signed [SW-1:0] s1 [3];
  logic signed [PW-1:0] p2 [3][3];

  if (POW2) begin : g_full
    assign lay_ok = 1'b1;
  end else begin : g_part
    assign lay_ok = (in_layer < LW'(NL));
  end
  assign ix0 = lay_ok ? in_layer : '0;

  assign adv        = ~v3 | out_ready;
  assign in_ready   = adv & ~upd_pend;
  assign accept     = in_valid & in_ready;
  assign pipe_empty = ~(v1 | v2 | v3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, v2, v3, en1, en2} <= '0;
      {lay1, lay2, ix1, ix2, lay3} <= '0;
      raw1 <= '0; raw2 <= '0; pix3 <= '0;
      for (int j = 0; j < 3; j++) s1[j] <= '0;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) p2[i][j] <= '0;
    end else if (adv) begin
      // stage 1: offsets
      v1   <= accept;
      lay1 <= in_layer;
      ix1  <= ix0;
      en1  <= lay_ok & sh_en[ix0];
      raw1 <= in_pix;
      for (int j = 0; j < 3; j++)
        s1[j] <= SW'(pix_offset(16'(in_pix[j]), sh_regs[ix0][j][WORDS-1][31:16]));
      // stage 2: products
      v2   <= v1;
      lay2 <= lay1;
      ix2  <= ix1;
      en2  <= en1;
      raw2 <= raw1;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          p2[i][j] <= PW'(pix_mul(sh_regs[ix1][i][j], wide_t'(s1[j])));
      // stage 3: sum, constant, round, clamp
      v3   <= v2;
      lay3 <= lay2;
      for (int i = 0; i < 3; i++)
        pix3[i] <= en2 ? CW'(pix_finish(wide_t'(p2[i][0]), wide_t'(p2[i][1]),
                                        wide_t'(p2[i][2]),
                                        sh_regs[ix2][i][WORDS-1][15:0], MAXV))
                       : raw2[i];
    end
  end

  assign out_valid = v3;
  assign out_layer = lay3;
  assign out_pix   = pix3;
endmodule

// File: rtl/pix_csc.sv
`timescale 1ns/1ps
module pix_csc
  import csc_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int COMP_W = 10,
  parameter int ADDR_W = 12,
  localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic frame_start,
  input  logic in_valid,
  output logic in_ready,
  input  logic [LAYER_W-1:0] in_layer,
  input  logic [COMP_W-1:0] in_c0,
  input  logic [COMP_W-1:0] in_c1,
  input  logic [COMP_W-1:0] in_c2,
  output logic out_valid,
  input  logic out_ready,
  output logic [LAYER_W-1:0] out_layer,
  output logic [COMP_W-1:0] out_c0,
  output logic [COMP_W-1:0] out_c1,
  output logic [COMP_W-1:0] out_c2
);
  logic upd_pend, shadow_load, pipe_empty, accept;
  logic [NUM_LAYERS-1:0] sh_en;
  logic [NUM_LAYERS-1:0][ROWS-1:0][WORDS-1:0][31:0] sh_regs;
  logic [2:0][COMP_W-1:0] in_pix, out_pix;

  assign in_pix = {in_c2, in_c1, in_c0};
  assign out_c0 = out_pix[0];
  assign out_c1 = out_pix[1];
  assign out_c2 = out_pix[2];

  csc_regfile #(.NL(NUM_LAYERS), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_start(frame_start),
    .pipe_empty(pipe_empty), .upd_pend(upd_pend), .shadow_load(shadow_load),
    .sh_en(sh_en), .sh_regs(sh_regs)
  );

  csc_pipe #(.NL(NUM_LAYERS), .CW(COMP_W), .LW(LAYER_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .sh_en(sh_en), .sh_regs(sh_regs),
    .upd_pend(upd_pend), .in_valid(in_valid), .in_ready(in_ready),
    .in_layer(in_layer), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_layer(out_layer), .out_pix(out_pix),
    .pipe_empty(pipe_empty), .accept(accept)
  );
endmodule

// File: rtl/csc_chk.sv
`timescale 1ns/1ps
module csc_chk #(
  parameter int CW = 10,
  parameter int LW = 2
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic in_ready,
  input logic accept,
  input logic out_valid,
  input logic out_ready,
  input logic [LW-1:0] out_layer,
  input logic [3*CW-1:0] out_pix,
  input logic upd_pend,
  input logic shadow_load,
  input logic pipe_empty
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_layer));

  // R10
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend |-> !in_ready && !accept);

  // R10
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load |-> pipe_empty);

  // R10
  fs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> upd_pend);

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend && !pipe_empty |=> upd_pend);
endmodule

bind pix_csc csc_chk #(.CW(COMP_W), .LW(LAYER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_ready(in_ready),
  .accept(accept), .out_valid(out_valid), .out_ready(out_ready),
  .out_layer(out_layer), .out_pix({out_c2, out_c1, out_c0}),
  .upd_pend(upd_pend), .shadow_load(shadow_load), .pipe_empty(pipe_empty)
);

// File: tb/tb_pix_csc.sv
`timescale 1ns/1ps
module tb_pix_csc;
  localparam int NL = 4, CW = 10, AW = 12, LW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0, frame_start = 0, in_valid = 0, out_ready = 1;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_ready, out_valid;
  logic [LW-1:0] in_layer = '0, out_layer;
  logic [CW-1:0] in_c0 = '0, in_c1 = '0, in_c2 = '0, out_c0, out_c1, out_c2;

  pix_csc dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, acc_cyc = 0;
  int unsigned m_prog [NL][3][4];
  int unsigned m_sh   [NL][3][4];
  bit [NL-1:0] m_en = '0, m_sh_en = '0;
  logic [31:0] expq [$];
  logic [CW-1:0] lo0, lo1, lo2;
  bit bp_on = 0, hold_armed = 0;
  logic [3*CW+LW-1:0] hold_val;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin #1; out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1; end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  // expected output of one row, from R4/R5/R6
  function automatic int model(int l, int row, int a, int b, int c);
    int px[3];
    longint acc;
    px = '{a, b, c};
    if (!m_sh_en[l]) return px[row];
    acc = longint'($signed(m_sh[l][row][3][15:0])) * 131072 + 65536;
    for (int j = 0; j < 3; j++)
      acc += longint'($signed(m_sh[l][row][j])) *
             (longint'(px[j]) + longint'($signed(m_sh[l][j][3][31:16])));
    acc = acc >>> 17;
    if (acc < 0) return 0;
    if (acc > 1023) return 1023;
    return int'(acc);
  endfunction

  // output monitor (R4..R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_armed)
        check(out_valid && {out_layer, out_c2, out_c1, out_c0} == hold_val, "R9",
              "stall hold", {out_layer, out_c2, out_c1, out_c0}, hold_val);
      hold_armed = out_valid && !out_ready;
      hold_val = {out_layer, out_c2, out_c1, out_c0};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R9", "unexpected output", 1, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check({out_layer, out_c2, out_c1, out_c0} == e, "R4",
                "pixel", {out_layer, out_c2, out_c1, out_c0}, e);
        end
        lo0 = out_c0; lo1 = out_c1; lo2 = out_c2;
      end
    end
  end

  task automatic wr(int addr, int unsigned data);
    reg_wr_en = 1; reg_addr = AW'(addr); reg_wdata = data;
    @(posedge clk); #1;
    reg_wr_en = 0;
    if (addr == 'h100) m_en = data[NL-1:0];
    else if (addr >= 'h110 && addr < 'h110 + 'h30 * NL && ((addr - 'h110) % 'h30) < 'h30 &&
             (addr % 4) == 0) begin
      int l, r, w;
      l = (addr - 'h110) / 'h30;
      r = ((addr - 'h110) % 'h30) / 'h10;
      w = ((addr - 'h110) % 'h10) / 4;
      m_prog[l][r][w] = data;
    end
  endtask

  task automatic rd_chk(int addr, int unsigned exp, string req);
    reg_addr = AW'(addr);
    @(negedge clk);
    check(reg_rdata == exp, req, $sformatf("read 0x%0h", addr), reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic fs();
    frame_start = 1;
    @(posedge clk); #1;
    frame_start = 0;
    m_sh = m_prog; m_sh_en = m_en;
  endtask

  task automatic push(int l, int a, int b, int c);
    in_valid = 1; in_layer = LW'(l);
    in_c0 = CW'(a); in_c1 = CW'(b); in_c2 = CW'(c);
    do @(negedge clk); while (!in_ready);
    expq.push_back({LW'(l), CW'(model(l, 2, a, b, c)), CW'(model(l, 1, a, b, c)),
                    CW'(model(l, 0, a, b, c))});
    acc_cyc = cyc;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic bank(int l, int unsigned c [9], int d0, int d1, int d2, int k0, int k1, int k2);
    int d[3], k[3];
    d = '{d0, d1, d2}; k = '{k0, k1, k2};
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < 3; w++) wr('h110 + 'h30 * l + 'h10 * r + 4 * w, c[r * 3 + w]);
      wr('h110 + 'h30 * l + 'h10 * r + 12, {d[r][15:0], k[r][15:0]});
    end
  endtask

  initial begin
    int unsigned yuv [9], yvu [9], half [9], rnd [9];
    logic [CW-1:0] s0, s1, s2;
    int first;
    void'($urandom(32'd2024));
    for (int l = 0; l < NL; l++) for (int r = 0; r < 3; r++) for (int w = 0; w < 4; w++) begin
      m_prog[l][r][w] = 0; m_sh[l][r][w] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
    rd_chk('h100, 0, "R1");
    rd_chk('h110, 0, "R1");
    rd_chk('h1CC, 0, "R1");
    // R6: disabled layer passes through
    push(2, 123, 456, 789); drain();
    check({lo2, lo1, lo0} == {10'd789, 10'd456, 10'd123}, "R6", "passthrough",
          {lo2, lo1, lo0}, {10'd789, 10'd456, 10'd123});
    // R2: readback of every bank word
    for (int l = 0; l < NL; l++) for (int r = 0; r < 3; r++) for (int w = 0; w < 4; w++)
      wr('h110 + 'h30 * l + 'h10 * r + 4 * w, $urandom);
    for (int l = 0; l < NL; l++) for (int r = 0; r < 3; r++) for (int w = 0; w < 4; w++)
      rd_chk('h110 + 'h30 * l + 'h10 * r + 4 * w, m_prog[l][r][w], "R2");
    wr('h104, 32'hDEADBEEF);
    rd_chk('h104, 0, "R2");
    rd_chk('h1D0, 0, "R2");
    rd_chk('h10C, 0, "R2");
    rd_chk('h110, m_prog[0][0][0], "R2");
    // R3
    wr('h100, 32'hFFFF_FFF5);
    rd_chk('h100, 32'h5, "R3");
    // YUV / YVU banks
    yuv = '{32'h0002542A, 32'h0, 32'h0003312A,
            32'h0002542A, 32'hFFFF376B, 32'hFFFE5FC3,
            32'h0002542A, 32'h000408D3, 32'h0};
    yvu = '{32'h0002542A, 32'h0003312A, 32'h0,
            32'h0002542A, 32'hFFFE5FC3, 32'hFFFF376B,
            32'h0002542A, 32'h0, 32'h000408D3};
    half = '{32'h00010000, 0, 0, 0, 0, 0, 0, 0, 0};
    bank(0, yuv, -64, -512, -512, 0, 0, 0);
    bank(1, yvu, -64, -512, -512, 0, 0, 0);
    bank(2, half, 0, 0, 0, 0, 100, -4);
    wr('h100, 32'h7);
    // R10: not applied before frame start (layer 0 still old/disabled)
    push(0, 940, 512, 512); drain();
    check({lo2, lo1, lo0} == {10'd512, 10'd512, 10'd940}, "R10", "before frame start",
          {lo2, lo1, lo0}, {10'd512, 10'd512, 10'd940});
    fs();
    // R8: latency
    push(0, 64, 512, 512);
    @(negedge clk); check(out_valid == 0, "R8", "valid after e", out_valid, 0);
    @(negedge clk); check(out_valid == 0, "R8", "valid after e+1", out_valid, 0);
    @(negedge clk); check(out_valid == 1, "R8", "valid after e+2", out_valid, 1);
    drain();
    check({lo2, lo1, lo0} == 30'd0, "R4", "black", {lo2, lo1, lo0}, 0);
    push(0, 940, 512, 512); drain();
    check(lo0 == 1020 && lo1 == 1020 && lo2 == 1020, "R4", "white", lo0, 1020);
    // R5: saturation high and low, rounding half-up
    push(0, 1023, 1023, 1023); drain();
    check(lo0 == 1023, "R5", "clamp high", lo0, 1023);
    push(0, 0, 512, 512); drain();
    check({lo2, lo1, lo0} == 30'd0, "R5", "clamp low", {lo2, lo1, lo0}, 0);
    push(2, 3, 0, 0); drain();
    check(lo0 == 2 && lo1 == 100 && lo2 == 0, "R5", "round 1.5", lo0, 2);
    push(2, 5, 0, 0); drain();
    check(lo0 == 3, "R5", "round 2.5", lo0, 3);
    // R11: swapped chroma columns
    push(0, 700, 300, 800); drain();
    s0 = lo0; s1 = lo1; s2 = lo2;
    push(1, 700, 800, 300); drain();
    check({lo2, lo1, lo0} == {s2, s1, s0}, "R11", "column swap", {lo2, lo1, lo0}, {s2, s1, s0});
    // R7: layer index selects bank
    push(3, 10, 20, 30); drain();
    check({lo2, lo1, lo0} == {10'd30, 10'd20, 10'd10}, "R7", "layer 3 disabled",
          {lo2, lo1, lo0}, {10'd30, 10'd20, 10'd10});
    // R10: shadow load waits for drain
    wr('h110 + 'h60 + 'h10 + 12, {16'd0, 16'd200});
    push(2, 8, 0, 0);
    push(2, 8, 0, 0);
    fs();
    @(negedge clk);
    check(in_ready == 0, "R10", "in_ready during drain", in_ready, 0);
    @(posedge clk); #1;
    push(2, 8, 0, 0); drain();
    check(lo1 == 200, "R10", "new constant", lo1, 200);
    // R8: throughput
    push(0, 100, 500, 600); first = acc_cyc;
    for (int n = 0; n < 7; n++) push(n % 4, 100 + n, 500, 600);
    check(acc_cyc - first == 7, "R8", "8 pixels accept cycles", acc_cyc - first, 7);
    drain();
    // R9 + random traffic
    bp_on = 1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int l = 0; l < NL; l++) begin
        int dd[3], kk[3];
        for (int i = 0; i < 9; i++) rnd[i] = $urandom_range(0, 1 << 20) - (1 << 19);
        for (int i = 0; i < 3; i++) begin
          dd[i] = int'($urandom_range(0, 1400)) - 700;
          kk[i] = int'($urandom_range(0, 1400)) - 700;
        end
        bank(l, rnd, dd[0], dd[1], dd[2], kk[0], kk[1], kk[2]);
      end
      wr('h100, $urandom);
      fs();
      for (int n = 0; n < 200; n++)
        push($urandom_range(0, NL - 1), $urandom_range(0, 1023), $urandom_range(0, 1023),
             $urandom_range(0, 1023));
    end
    drain();
    bp_on = 0;
    repeat (4) @(posedge clk);
    check(expq.size() == 0, "R9", "all pixels delivered", expq.size(), 0);
    report();
  end
endmodule